// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block owns the program counter of a small processor whose instructions are 16-bit words held in byte-addressed program memory. Every cycle it presents an even byte address to a combinational program-memory read port, classifies the returned word, and hands decoded instructions to the datapath over a valid/ready stream. The next address is the sequential one, an absolute jump target, a relative branch target, or one word further on when the datapath asks for a skip.

Some instructions occupy two consecutive words. The first word is held in an internal register while the second word is fetched, and one combined instruction is then issued that carries both words' operands. Every second word has 1111 in its top four bits. A word with that prefix that is reached without its first word in front of it is issued as a no-operation. A skip therefore only ever moves one word ahead, even when the word it skips over begins a two-word instruction.

Stream rules: `ins_valid` does not depend on `ins_ready`. While `ins_valid` is high and `ins_ready` is low, every `ins_*` output and `imem_addr` stay unchanged. An instruction is consumed on a rising edge with both high. `skip_req` and `br_taken` are sampled only on that edge, so the datapath drives them together with `ins_ready` in response to the instruction on offer. A first word is absorbed without a handshake, and `ins_valid` is low during that cycle.

Top module: `fetch_seq`

## Requirements
- R1: While reset is asserted `imem_addr` is 0, and the first instruction issued after reset comes from byte address 0.
- R2: `imem_addr` bit 0 is always 0. After a one-word instruction (kind 1) is consumed without a skip, the next fetch is at its address plus 2.
- R3: While `ins_valid` is high and `ins_ready` is low, `imem_addr` and every `ins_*` output hold their values on the next cycle.
- R4: A first word (top byte EFh for a jump, top nibble 1100 for a move) is never issued alone. In its cycle `ins_valid` is low and the address advances by 2. The combined instruction then reports the first word's address in `ins_addr` and the first word itself in `ins_word`.
- R5: A jump (kind 3) has the target byte address 2 × {second[11:0], first[7:0]}, reported in `ins_target`, and fetching continues there.
- R6: A move (kind 4) reports source = first[11:0] and destination = second[11:0], and fetching continues after the second word.
- R7: A word with top bits 11010 is a branch (kind 2) with an 11-bit signed word offset in bits 10:0. `ins_target` = address + 2 + 2 × offset, modulo 2^21. When it is consumed, fetching continues at `ins_target` if `br_taken` is high, and otherwise at address + 2.
- R8: A one-word instruction consumed with `skip_req` high moves the next fetch to its address plus 4. `skip_req` has no effect on any other kind.
- R9: A word with top nibble 1111 and no pending first word is issued as a no-operation (kind 0) with `ins_word` equal to that word, and fetching advances by 2.
- R10: If a pending first word is followed by a word without the 1111 prefix, the first word is issued as a no-operation at its own address. The following word is then fetched again from the same address and handled as a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 21 | Byte address of the word being fetched |
| imem_rdata | input | 16 | Word at `imem_addr`, returned in the same cycle |
| skip_req | input | 1 | Skip one word after the consumed one-word instruction |
| br_taken | input | 1 | The consumed branch is taken |
| ins_valid | output | 1 | An instruction is on offer |
| ins_ready | input | 1 | The datapath accepts the instruction on offer |
| ins_kind | output | 3 | 0 no-op, 1 one-word, 2 branch, 3 jump, 4 move |
| ins_addr | output | 21 | Byte address of the instruction's first word |
| ins_word | output | 16 | The instruction's first (or only) word |
| ins_target | output | 21 | Branch or jump target byte address, 0 for the other kinds |
| ins_src | output | 12 | Move source field, 0 for the other kinds |
| ins_dst | output | 12 | Move destination field, 0 for the other kinds |

## Verification
A corrupted pending flag or held first word shows up at the stream port on the very next issued instruction. The symptoms are a second word issued with a combined kind where a no-op is due, a no-op where a jump or move is due, or an `ins_addr` two bytes off. A wrong next-address choice after a skip, branch or jump appears one handshake later as a mismatch between the expected and the reported `ins_addr`. A first word absorbed at the wrong time shows as `ins_valid` low at an address that does not hold a first word. The bench runs many generated programs that mix every word class, with random back-pressure, skips and branch decisions, and compares each issued instruction with an address-level model.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int WORD_W = 16;
  localparam int LIT_W  = 12;

  typedef enum logic [2:0] {
    K_NOP    = 3'd0,
    K_SINGLE = 3'd1,
    K_BRANCH = 3'd2,
    K_JUMP   = 3'd3,
    K_MOVE   = 3'd4
  } ins_kind_e;

  typedef enum logic [2:0] {
    C_PLAIN,
    C_TAIL,
    C_BRANCH,
    C_JMP1,
    C_MOV1
  } word_class_e;

  localparam logic [7:0] JMP1_TOP   = 8'hEF;
  localparam logic [3:0] MOV1_TOP   = 4'hC;
  localparam logic [3:0] TAIL_TOP   = 4'hF;
  localparam logic [4:0] BRANCH_TOP = 5'b11010;
endpackage

// File: rtl/fetch_classify.sv
module fetch_classify
  import fetch_pkg::*;
(
  input  logic [7:0]  top_i,
  output word_class_e cls_o
);
  always_comb begin
    if (top_i[7:4] == TAIL_TOP)        cls_o = C_TAIL;
    else if (top_i == JMP1_TOP)        cls_o = C_JMP1;
    else if (top_i[7:4] == MOV1_TOP)   cls_o = C_MOV1;
    else if (top_i[7:3] == BRANCH_TOP) cls_o = C_BRANCH;
    else                               cls_o = C_PLAIN;
  end
endmodule

// File: rtl/fetch_target.sv
module fetch_target #(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [7:0]        jlo_i,
  input  logic [11:0]       jhi_i,
  input  logic [10:0]       boff_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] skip_o,
  output logic [ADDR_W-1:0] br_o,
  output logic [ADDR_W-1:0] jmp_o
);
  localparam int JW   = 20;
  localparam int WA_W = ADDR_W - 1;
  localparam int OFF_W = 11;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [JW-1:0]     jword;
  logic [ADDR_W-1:0] off_bytes;

  assign jword     = {jhi_i, jlo_i};
  assign off_bytes = {{(ADDR_W-OFF_W-1){boff_i[OFF_W-1]}}, boff_i, 1'b0};

  assign seq_o  = pc_i + STEP;
  assign skip_o = pc_i + STEP + STEP;
  assign br_o   = pc_i + STEP + off_bytes;

  generate
    if (WA_W > JW) begin : g_wide
      assign jmp_o = {{(WA_W-JW){1'b0}}, jword, 1'b0};
    end else if (WA_W == JW) begin : g_exact
      assign jmp_o = {jword, 1'b0};
    end else begin : g_narrow
      assign jmp_o = {jword[WA_W-1:0], 1'b0};
    end
  endgenerate
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [15:0]       imem_rdata,
  input  logic              skip_req,
  input  logic              br_taken,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [2:0]        ins_kind,
  output logic [ADDR_W-1:0] ins_addr,
  output logic [15:0]       ins_word,
  output logic [ADDR_W-1:0] ins_target,
  output logic [11:0]       ins_src,
  output logic [11:0]       ins_dst
);
  logic [ADDR_W-1:0] pc_q, nxt_pc;
  logic              pend_q, nxt_pend;
  logic              hold_jmp_q;
  logic [15:0]       hold_w_q;
  logic [ADDR_W-1:0] hold_pc_q;
  logic              load_hold;
  logic              fire;
  word_class_e       cls;
  logic [ADDR_W-1:0] seq_pc, skip_pc, br_pc, jmp_pc;

  fetch_classify u_cls (
    .top_i (imem_rdata[15:8]),
    .cls_o (cls)
  );

  fetch_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc_i   (pc_q),
    .jlo_i  (hold_w_q[7:0]),
    .jhi_i  (imem_rdata[11:0]),
    .boff_i (imem_rdata[10:0]),
    .seq_o  (seq_pc),
    .skip_o (skip_pc),
    .br_o   (br_pc),
    .jmp_o  (jmp_pc)
  );

  assign imem_addr = pc_q;
  assign fire      = ins_valid && ins_ready;

  always_comb begin
    ins_valid  = 1'b0;
    ins_kind   = K_NOP;
    ins_addr   = pc_q;
    ins_word   = imem_rdata;
    ins_target = '0;
    ins_src    = '0;
    ins_dst    = '0;
    nxt_pc     = pc_q;
    nxt_pend   = pend_q;
    load_hold  = 1'b0;
    if (!pend_q) begin
      unique case (cls)
        C_JMP1, C_MOV1: begin
          load_hold = 1'b1;
          nxt_pend  = 1'b1;
          nxt_pc    = seq_pc;
        end
        C_TAIL: begin
          ins_valid = 1'b1;
          ins_kind  = K_NOP;
          if (ins_ready) nxt_pc = seq_pc;
        end
        C_BRANCH: begin
          ins_valid  = 1'b1;
          ins_kind   = K_BRANCH;
          ins_target = br_pc;
          if (ins_ready) nxt_pc = br_taken ? br_pc : seq_pc;
        end
        default: begin
          ins_valid = 1'b1;
          ins_kind  = K_SINGLE;
          if (ins_ready) nxt_pc = skip_req ? skip_pc : seq_pc;
        end
      endcase
    end else begin
      ins_valid = 1'b1;
      ins_addr  = hold_pc_q;
      ins_word  = hold_w_q;
      if (cls == C_TAIL) begin
        if (hold_jmp_q) begin
          ins_kind   = K_JUMP;
          ins_target = jmp_pc;
          if (ins_ready) nxt_pc = jmp_pc;
        end else begin
          ins_kind = K_MOVE;
          ins_src  = hold_w_q[11:0];
          ins_dst  = imem_rdata[11:0];
          if (ins_ready) nxt_pc = seq_pc;
        end
      end else begin
        ins_kind = K_NOP;
        nxt_pc   = pc_q;
      end
      if (ins_ready) nxt_pend = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= '0;
      pend_q     <= 1'b0;
      hold_jmp_q <= 1'b0;
      hold_w_q   <= '0;
      hold_pc_q  <= '0;
    end else begin
      pc_q   <= nxt_pc;
      pend_q <= nxt_pend;
      if (load_hold) begin
        hold_jmp_q <= (cls == C_JMP1);
        hold_w_q   <= imem_rdata;
        hold_pc_q  <= pc_q;
      end
    end
  end

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_addr) && $stable(ins_kind)
      && $stable(ins_word) && $stable(imem_addr));

  p_first_absorbed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && (imem_rdata[15:8] == JMP1_TOP || imem_rdata[15:12] == MOV1_TOP)
      |=> ins_valid && ins_addr == $past(imem_addr)
      && imem_addr == ADDR_W'($past(imem_addr) + ADDR_W'(2)));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ins_kind == K_SINGLE && !skip_req
      |=> imem_addr == ADDR_W'($past(imem_addr) + ADDR_W'(2)));

  p_skip_one_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ins_kind == K_SINGLE && skip_req
      |=> imem_addr == ADDR_W'($past(imem_addr) + ADDR_W'(4)));

  p_lone_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && imem_rdata[15:12] == TAIL_TOP |-> ins_valid && ins_kind == K_NOP);

  p_orphan_refetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && imem_rdata[15:12] != TAIL_TOP && ins_ready
      |=> !pend_q && imem_addr == $past(imem_addr));
endmodule

// File: tb/tb_fetch_seq.sv
`timescale 1ns/1ps
module tb_fetch_seq;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [15:0]   imem_rdata;
  logic          skip_req = 1'b0;
  logic          br_taken = 1'b0;
  logic          ins_valid;
  logic          ins_ready = 1'b0;
  logic [2:0]    ins_kind;
  logic [AW-1:0] ins_addr;
  logic [15:0]   ins_word;
  logic [AW-1:0] ins_target;
  logic [11:0]   ins_src;
  logic [11:0]   ins_dst;

  logic [15:0] mem [128];
  int vec = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  assign imem_rdata = mem[imem_addr[7:1]];

  fetch_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .skip_req(skip_req), .br_taken(br_taken), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_kind(ins_kind), .ins_addr(ins_addr),
    .ins_word(ins_word), .ins_target(ins_target), .ins_src(ins_src), .ins_dst(ins_dst)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [15:0] rd(input logic [AW-1:0] a);
    return mem[a[7:1]];
  endfunction

  function automatic logic is_tail(input logic [15:0] w);
    return w[15:12] == 4'hF;
  endfunction

  function automatic logic is_first(input logic [15:0] w);
    return (w[15:8] == 8'hEF) || (w[15:12] == 4'hC);
  endfunction

  function automatic logic is_br(input logic [15:0] w);
    return w[15:11] == 5'b11010;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int scen);
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    if (scen == 0) begin
      mem[0] = 16'hEF03;
      mem[1] = 16'hF000;
      mem[3] = 16'h1234;
    end else begin
      for (int i = 0; i < 128; i++) begin
        logic [31:0] r;
        logic [10:0] off;
        r = rnd();
        off = 11'(signed'(r[19:16]) );
        case (r[2:0])
          3'd0: mem[i] = {8'hEF, r[15:8]};
          3'd1: mem[i] = {4'hC, r[19:8]};
          3'd2: mem[i] = {4'hF, r[19:8]};
          3'd3: mem[i] = {5'b11010, (r[20] ? {{7{r[19]}}, r[19:16]} : r[30:20])};
          default: mem[i] = {4'(r[11:8] % 4'd12), r[23:12]};
        endcase
        if (off == 11'h7FF) mem[i] = mem[i];
      end
    end
  endtask

  task automatic run(input int nh);
    logic [AW-1:0] m_pc;
    logic [AW-1:0] held_addr;
    logic          held;
    string         tag;
    int            n;
    m_pc = '0;
    held = 1'b0;
    held_addr = '0;
    tag = "R1";
    n = 0;
    while (n < nh) begin
      logic [15:0]   w, t;
      logic [2:0]    ek;
      logic [AW-1:0] etgt, nxt_seq, nxt;
      logic [11:0]   esrc, edst;
      logic [31:0]   r;
      logic          rdy, sk, tk;
      string         ktag;
      @(negedge clk);
      if (held) check("R3", "imem_addr held", 32'(imem_addr), 32'(held_addr));
      if (!ins_valid) begin
        check("R4", "bubble address", 32'(imem_addr), 32'(m_pc));
        check("R4", "bubble on first word", 32'(is_first(rd(m_pc))), 32'd1);
        held = 1'b0;
        r = rnd();
        ins_ready = r[0];
        continue;
      end
      w = rd(m_pc);
      t = rd(AW'(m_pc + AW'(2)));
      etgt = '0; esrc = '0; edst = '0;
      nxt_seq = AW'(m_pc + AW'(2));
      r = rnd();
      rdy = (r[3:0] != 4'd0);
      sk = r[4];
      tk = r[5];
      if (is_first(w)) begin
        if (is_tail(t)) begin
          if (w[15:8] == 8'hEF) begin
            ek = 3'd3; ktag = "R5";
            etgt = {t[11:0], w[7:0], 1'b0};
            nxt = etgt;
          end else begin
            ek = 3'd4; ktag = "R6";
            esrc = w[11:0]; edst = t[11:0];
            nxt = AW'(m_pc + AW'(4));
          end
        end else begin
          ek = 3'd0; ktag = "R10";
          nxt = nxt_seq;
        end
      end else if (is_tail(w)) begin
        ek = 3'd0; ktag = "R9";
        nxt = nxt_seq;
      end else if (is_br(w)) begin
        ek = 3'd2; ktag = "R7";
        etgt = AW'(m_pc + AW'(2) + AW'({{(AW-12){w[10]}}, w[10:0], 1'b0}));
        nxt = tk ? etgt : nxt_seq;
      end else begin
        ek = 3'd1; ktag = "R2";
        nxt = sk ? AW'(m_pc + AW'(4)) : nxt_seq;
      end
      check(ktag, "ins_kind", 32'(ins_kind), 32'(ek));
      check(is_first(w) ? "R4" : tag, "ins_addr", 32'(ins_addr), 32'(m_pc));
      check(ktag, "ins_word", 32'(ins_word), 32'(w));
      if (ek == 3'd2 || ek == 3'd3) check(ktag, "ins_target", 32'(ins_target), 32'(etgt));
      if (ek == 3'd4) begin
        check("R6", "ins_src", 32'(ins_src), 32'(esrc));
        check("R6", "ins_dst", 32'(ins_dst), 32'(edst));
      end
      ins_ready = rdy;
      skip_req = sk;
      br_taken = tk;
      if (rdy) begin
        m_pc = nxt;
        n++;
        held = 1'b0;
        if (ek == 3'd1 && sk) tag = "R8";
        else if (ek == 3'd2) tag = "R7";
        else if (ek == 3'd3) tag = "R5";
        else if (ek == 3'd4) tag = "R6";
        else if (ek == 3'd0 && ktag == "R10") tag = "R10";
        else if (ek == 3'd0) tag = "R9";
        else tag = "R2";
      end else begin
        held = 1'b1;
        held_addr = imem_addr;
      end
    end
    @(negedge clk);
    ins_ready = 1'b0;
    skip_req = 1'b0;
    br_taken = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < 30; s++) begin
      ins_ready = 1'b0;
      skip_req = 1'b0;
      br_taken = 1'b0;
      fill(s);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "address in reset", 32'(imem_addr), 32'd0);
      check("R2", "address bit 0 in reset", 32'(imem_addr[0]), 32'd0);
      rst_n = 1'b1;
      run(s == 0 ? 4 : 300);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule